// File: doc/BRIEF.md
# Datapath Self-Test Signature Engine

This block exercises the digital back end of a two-channel, 16-bit sample path without the converter. On an accepted start it drives pseudorandom samples into the point where converter words enter the digital path. It then compresses the word that comes back out of that path, once per cycle, into a 16-bit signature. A run always lasts 512 sample cycles and then stops by itself. The injected samples stay visible on the block's outputs for the whole run, so the sequence can also be watched downstream while it runs.

Software controls the engine through a small byte-wide register port. One control register starts a run, picks the channels and chooses one of two PN modes. In the first mode the PN sequence starts again from its seed. In the second it resumes from where the previous run left it. Two read-only registers return the low and high bytes of the last signature. The two channels share one signature, and a fixed priority decides which channel's result is kept.

Top module: `bist_sig_engine`

## Requirements
- R1: After reset the signature bytes read 0x00, the done flag is low, both inject strobes are low, and the control register reads 0x00.
- R2: A write to address 0x0E with bit 0 set and at least one channel bit set (bit 1 channel A, bit 3 channel B) starts a run when the block is idle. From the next cycle, pnValid bit 0 (A) and bit 1 (B) are high for the selected channels.
- R3: A run lasts exactly 512 cycles. After the 512th cycle pnValid returns to zero and bistDone rises.
- R4: pnData carries the state of a 16-bit LFSR with feedback taps for x^16+x^14+x^13+x^11+1 and seed 0xFFFF. The state shifts left with the new bit entering at bit 0, and it advances once per run cycle.
- R5: The signature is cleared at the start of a run. Each run cycle it shifts like the LFSR and XORs in one datapath word. The final value reads at 0x24 (bits 7:0) and 0x25 (bits 15:8).
- R6: With only channel A selected the signature folds dpOutA. With only channel B selected it folds dpOutB. With both selected it folds dpOutA.
- R7: Control bit 2 set means a new run continues the PN sequence from its last state. Bit 2 clear means the run restarts the sequence from the seed.
- R8: bistDone stays high until the next accepted start. The signature bytes hold their value until the next run completes.
- R9: Any write to the control register while a run is in progress is ignored. The run is neither restarted nor extended, and its channel selection is unchanged.
- R10: A start written with no channel bit set begins no run. bistDone and the signature bytes stay as they were.
- R11: Reading 0x0E returns bit 0 = run in progress, bit 1 = channel A selected, bit 2 = continue mode, bit 3 = channel B selected, and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| dpOutA | input | 16 | Channel A word returned by the datapath |
| dpOutB | input | 16 | Channel B word returned by the datapath |
| pnData | output | 16 | Injected pseudorandom sample |
| pnValid | output | 2 | Per-channel inject strobe (bit 0 A, bit 1 B) |
| bistDone | output | 1 | Run complete flag |

## Verification
Two functions can meet in the same cycle: a control write can arrive on a cycle where the run is already stepping its counter and signature. The bench provokes this by writing a new start with a different channel selection partway through a run. It then checks that the run still ends after 512 cycles, that the signature matches the channel of the original selection, and that the control readback still shows that selection. The cycle that captures the final signature is also the cycle where done rises. That cycle is judged by reading both signature bytes and the flag right after it and comparing them with a bench model of the LFSR and the signature register.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int SIG_W = 16;
  localparam logic [SIG_W-1:0] TAP_MASK = 16'hB400; // x^16+x^14+x^13+x^11+1

  typedef struct packed {
    logic startRun;
    logic restartPn;
    logic stepEn;
    logic captureSig;
    logic useB;
  } bistStrobes_t;

  function automatic logic [SIG_W-1:0] shiftNext(input logic [SIG_W-1:0] s);
    return {s[SIG_W-2:0], ^(s & TAP_MASK)};
  endfunction
endpackage

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int RUN_LEN = 512,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output bistStrobes_t      strobes,
  output logic              running,
  output logic              done,
  output logic              selA,
  output logic              selB,
  output logic              keepPn
);
  localparam int CNT_W = $clog2(RUN_LEN);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cycleCnt;
  logic ctrlWrite, wantsChan, acceptStart, lastCycle;

  assign ctrlWrite   = wrEn && (wrAddr == CTRL_ADDR);
  assign wantsChan   = wrData[1] | wrData[3];
  assign acceptStart = ctrlWrite && !running && wrData[0] && wantsChan;
  assign lastCycle   = running && (cycleCnt == LAST_CNT);

  always_comb begin
    strobes.startRun   = acceptStart;
    strobes.restartPn  = acceptStart && !wrData[2];
    strobes.stepEn     = running;
    strobes.captureSig = lastCycle;
    strobes.useB       = selB && !selA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      done     <= 1'b0;
      cycleCnt <= '0;
      selA     <= 1'b0;
      selB     <= 1'b0;
      keepPn   <= 1'b0;
    end else begin
      if (acceptStart) begin
        running  <= 1'b1;
        done     <= 1'b0;
        cycleCnt <= '0;
      end else if (running) begin
        cycleCnt <= cycleCnt + 1'b1;
        if (lastCycle) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
      if (ctrlWrite && !running) begin
        selA   <= wrData[1];
        keepPn <= wrData[2];
        selB   <= wrData[3];
      end
    end
  end

  assert_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lastCycle |=> (!running && done));
  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !lastCycle) |=> (running && $stable({selA, selB, keepPn})));
  assert_no_chan_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWrite && !running && !wantsChan) |=> !running);
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !acceptStart) |=> done);
endmodule

// File: rtl/bist_datapath.sv
module bist_datapath
  import bist_pkg::*;
#(
  parameter logic [SIG_W-1:0] SEED = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bistStrobes_t     strobes,
  input  logic [SIG_W-1:0] dpA,
  input  logic [SIG_W-1:0] dpB,
  output logic [SIG_W-1:0] pnState,
  output logic [SIG_W-1:0] sigWord
);
  logic [SIG_W-1:0] misr, misrNext, foldWord;

  assign foldWord = strobes.useB ? dpB : dpA;
  assign misrNext = shiftNext(misr) ^ foldWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pnState <= SEED;
      misr    <= '0;
      sigWord <= '0;
    end else begin
      if (strobes.startRun) begin
        misr <= '0;
        if (strobes.restartPn) pnState <= SEED;
      end else if (strobes.stepEn) begin
        pnState <= shiftNext(pnState);
        misr    <= misrNext;
      end
      if (strobes.captureSig) sigWord <= misrNext;
    end
  end

  assert_pn_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pnState != '0);
  assert_misr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.startRun |=> (misr == '0));
  assert_sig_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.captureSig |=> $stable(sigWord));
endmodule

// File: rtl/bist_sig_engine.sv
module bist_sig_engine
  import bist_pkg::*;
#(
  parameter int RUN_LEN = 512,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] SIG_LO_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] SIG_HI_ADDR = 8'h25,
  parameter logic [SIG_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [SIG_W-1:0]  dpOutA,
  input  logic [SIG_W-1:0]  dpOutB,
  output logic [SIG_W-1:0]  pnData,
  output logic [1:0]        pnValid,
  output logic              bistDone
);
  bistStrobes_t strobes;
  logic running, selA, selB, keepPn;
  logic [SIG_W-1:0] sigWord;

  bist_ctrl #(.RUN_LEN(RUN_LEN), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(regWrEn), .wrAddr(regAddr), .wrData(regWrData),
    .strobes(strobes), .running(running), .done(bistDone),
    .selA(selA), .selB(selB), .keepPn(keepPn)
  );

  bist_datapath #(.SEED(SEED)) uPath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .dpA(dpOutA), .dpB(dpOutB),
    .pnState(pnData), .sigWord(sigWord)
  );

  assign pnValid = {selB, selA} & {2{running}};

  always_comb begin
    if (regAddr == CTRL_ADDR)        regRdData = {4'b0, selB, keepPn, selA, running};
    else if (regAddr == SIG_LO_ADDR) regRdData = sigWord[7:0];
    else if (regAddr == SIG_HI_ADDR) regRdData = sigWord[15:8];
    else                             regRdData = 8'h00;
  end

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bistDone |-> (pnValid == 2'b00));
endmodule

// File: tb/bist_sig_engine_test.sv
module bist_sig_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 512;
  localparam logic [7:0] CTRL = 8'h0E, SLO = 8'h24, SHI = 8'h25;
  // vector: bit 8 = expect channel B folded, bits 7:0 = control byte
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'h03}, {1'b1, 8'h09}, {1'b0, 8'h0B},
    {1'b0, 8'h07}, {1'b1, 8'h0D}, {1'b0, 8'h0F}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00, regWrData = 8'h00, regRdData;
  logic [15:0] dpOutA, dpOutB, pnData;
  logic [1:0] pnValid;
  logic bistDone;
  int total = 0, bad = 0;
  logic [15:0] ml = 16'hFFFF, mm = 16'h0000, lastSig = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_sig_engine uut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dpOutA(dpOutA), .dpOutB(dpOutB),
    .pnData(pnData), .pnValid(pnValid), .bistDone(bistDone)
  );

  // datapath stand-in: two different transforms of the injected sample
  function automatic logic [15:0] fA(input logic [15:0] p); return p ^ 16'h5A5A; endfunction
  function automatic logic [15:0] fB(input logic [15:0] p); return {p[7:0], p[15:8]} ^ 16'h0F0F; endfunction
  assign dpOutA = fA(pnData);
  assign dpOutB = fB(pnData);

  function automatic logic [15:0] stepPoly(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic readSig(output logic [15:0] s);
    logic [7:0] lo, hi;
    regRead(SLO, lo); regRead(SHI, hi);
    s = {hi, lo};
  endtask

  task automatic doRun(input logic [7:0] c, input logic expB, input int interfereAt);
    logic [7:0] rd;
    logic [15:0] sig;
    int errs;
    if (!c[2]) ml = 16'hFFFF;
    mm = 16'h0000;
    regWrite(CTRL, c);
    regRead(CTRL, rd);
    check(rd == {4'b0, c[3], c[2], c[1], 1'b1}, "R11 ctrl readback in run", rd, {4'b0, c[3], c[2], c[1], 1'b1});
    check(pnValid == {c[3], c[1]}, "R2 inject strobes", pnValid, {c[3], c[1]});
    check(bistDone == 1'b0, "R8 done cleared by start", bistDone, 0);
    errs = 0;
    for (int k = 0; k < RUN; k++) begin
      if (pnData !== ml) errs++;
      if (pnValid !== {c[3], c[1]}) errs++;
      mm = stepPoly(mm) ^ (expB ? fB(ml) : fA(ml));
      ml = stepPoly(ml);
      if (k == interfereAt) begin
        regAddr = CTRL; regWrData = 8'h09; regWrEn = 1'b1;
      end else begin
        regWrEn = 1'b0;
      end
      @(posedge clk); @(negedge clk);
    end
    regWrEn = 1'b0;
    check(errs == 0, c[2] ? "R7 R4 continued PN sequence" : "R4 PN sequence from seed", errs, 0);
    check(bistDone == 1'b1 && pnValid == 2'b00, "R3 stop after 512 cycles", {bistDone, pnValid}, 3'b100);
    readSig(sig);
    check(sig == mm, expB ? "R6 R5 signature of channel B" : "R6 R5 signature of channel A", sig, mm);
    lastSig = mm;
    if (interfereAt >= 0) begin
      regRead(CTRL, rd);
      check(rd == {4'b0, c[3], c[2], c[1], 1'b0}, "R9 selection kept after mid-run write", rd, {4'b0, c[3], c[2], c[1], 1'b0});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [15:0] sig;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    readSig(sig);
    check(sig == 16'h0000, "R1 signature after reset", sig, 0);
    check(bistDone == 1'b0 && pnValid == 2'b00, "R1 flags after reset", {bistDone, pnValid}, 0);
    regRead(CTRL, rd);
    check(rd == 8'h00, "R1 ctrl after reset", rd, 0);
    check(pnData == 16'hFFFF, "R4 seed on output", pnData, 16'hFFFF);

    for (int i = 0; i < 6; i++) doRun(VEC[i][7:0], VEC[i][8], -1);

    // R9 start with another selection in the middle of a channel-A run
    doRun(8'h03, 1'b0, 100);

    // R10 start with no channel selected
    regWrite(CTRL, 8'h05);
    check(pnValid == 2'b00 && bistDone == 1'b1, "R10 no run without channel", {bistDone, pnValid}, 3'b100);
    regRead(CTRL, rd);
    check(rd[0] == 1'b0, "R10 not running", rd, 8'h04);
    // R8 hold over idle time
    repeat (30) @(negedge clk);
    readSig(sig);
    check(sig == lastSig, "R8 R10 signature held", sig, lastSig);
    check(bistDone == 1'b1, "R8 done held", bistDone, 1);

    // R7 restart after a continued run returns to seed
    doRun(8'h0B, 1'b0, -1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule